// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Reset Domains

This block is a bank of general-purpose pins behind a small word-addressed register bus. A level register keeps two separate stores: writes go into an output latch, while reads return the pin as it is now, brought in through a synchronizer. The output latch drives a pin only when that pin is in GPIO mode and its direction input selects output. In native mode a write is still kept in the latch, but the pin is not driven.

A reset-select register gives each pin one of two reset domains. In the broad domain, the pin's latch returns to its default on any of these events:

- power-good loss
- system reset
- a warm reset-control write carrying one of two configured codes

In the suspend domain, only suspend-well reset clears the pin's latch. Suspend-well reset returns every latch bit and the reset-select register itself to their defaults. Parameters set which bits exist in each register, their default values and the depth of the synchronizer.

Top module: `gpio_rdom_bank`

## Requirements
- R1: A bus write to the level register (address LVL_ADDR) stores the write data masked by IMPL_MASK. On the clock edge that takes the write, a pin in GPIO mode with its direction set to output drives the stored bit: 1 high, 0 low.
- R2: `pin_oe_o[i]` is 1 only when bit i is implemented, `gpio_mode_i[i]`=1 and `dir_out_i[i]`=1. `pin_o[i]` is 0 whenever `pin_oe_o[i]` is 0.
- R3: When `gpio_mode_i[i]`=0 (native mode), a write to bit i does not change `pin_o[i]` or `pin_oe_o[i]`. The written value is still stored, and it drives the pin once the bit returns to GPIO output mode.
- R4: A read of the level register returns `pin_i` delayed by SYNC_STAGES clock edges and masked by IMPL_MASK. It never returns the output latch.
- R5: Level bits outside IMPL_MASK read 0. Writes to them are ignored, so they never drive a pin.
- R6: Reset-select bits outside RSEL_WMASK read 0 and ignore writes. Bits inside the mask store the written value, readable at address RSEL_ADDR.
- R7: A broad reset event returns to LVL_INIT every latch bit whose reset-select bit is 0. Bits whose select bit is 1 keep their value. A broad reset event is any one of: `pwrok_fall_i`, `sys_rst_i`, or `rstctl_we_i` with `rstctl_data_i` equal to RCTL_CODE_A or RCTL_CODE_B. A reset-control write with any other code has no effect.
- R8: `susp_rst_i` returns every latch bit to LVL_INIT and the reset-select register to RSEL_INIT, whatever the select values are.
- R9: When a clear and a bus write to the same register fall in one cycle, the clear wins for every bit it covers.
- R10: After `rst_n` is released, the latch holds LVL_INIT&IMPL_MASK and the reset-select register holds RSEL_INIT&RSEL_WMASK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Register word address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, combinational; 0 when not selected |
| pwrok_fall_i | input | 1 | Power-good deassertion pulse |
| rstctl_we_i | input | 1 | Reset-control register write pulse |
| rstctl_data_i | input | 8 | Reset-control write data |
| sys_rst_i | input | 1 | System reset pulse |
| susp_rst_i | input | 1 | Suspend-well reset pulse |
| gpio_mode_i | input | DW | Per pin: 1 = GPIO, 0 = native |
| dir_out_i | input | DW | Per pin: 1 = output, 0 = input |
| pin_i | input | DW | Pin levels |
| pin_o | output | DW | Pin drive values |
| pin_oe_o | output | DW | Pin output enables |

## Verification
The bench keeps DW=32, IMPL_MASK=0F0Fh and RSEL_WMASK=FF00FF00h. It overrides LVL_INIT to 0A05h and RSEL_INIT to 0300h, so that default values and select bits both land on implemented level bits. A broad reset can then leave a visible mix of cleared and kept pins, and a clear-versus-write collision gives a result that differs from either outcome alone. SYNC_STAGES stays at 2, which places the read-path latency where a one-cycle check can tell it apart.

// File: rtl/gpio_rdom_pkg.sv
package gpio_rdom_pkg;

   // decoded reset events for one cycle
   typedef struct packed {
      logic broad;   // power-good loss, system reset or matching reset-control code
      logic susp;    // suspend-well reset
   } rst_evt_t;

   function automatic logic code_hit(input logic [7:0] d,
                                     input logic [7:0] a,
                                     input logic [7:0] b);
      return (d == a) || (d == b);
   endfunction

endpackage

// File: rtl/gpio_rdom_rstdec.sv
module gpio_rdom_rstdec
   import gpio_rdom_pkg::*;
#(
   parameter logic [7:0] RCTL_CODE_A = 8'h06,
   parameter logic [7:0] RCTL_CODE_B = 8'h0E
) (
   input  logic       pwrok_fall_i,
   input  logic       rstctl_we_i,
   input  logic [7:0] rstctl_data_i,
   input  logic       sys_rst_i,
   input  logic       susp_rst_i,
   output rst_evt_t   evt_o
);

   logic rctl_hit;

   always_comb begin
      rctl_hit    = rstctl_we_i & code_hit(rstctl_data_i, RCTL_CODE_A, RCTL_CODE_B);
      evt_o.broad = pwrok_fall_i | sys_rst_i | rctl_hit;
      evt_o.susp  = susp_rst_i;
   end

endmodule

// File: rtl/gpio_rdom_sync.sv
module gpio_rdom_sync #(
   parameter int DW     = 32,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] d_i,
   output logic [DW-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [DW-1:0] stg_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
            end else begin
               stg_q[0] <= d_i;
               for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
            end
         end

         assign q_o = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/gpio_rdom_rsel.sv
module gpio_rdom_rsel #(
   parameter int            DW    = 32,
   parameter logic [DW-1:0] WMASK = 32'hFF00_FF00,
   parameter logic [DW-1:0] INIT  = 32'h0100_0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          susp_i,
   input  logic          wr_en_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rsel_o
);

   localparam logic [DW-1:0] RST_VAL = INIT & WMASK;

   logic [DW-1:0] sel_q;
   logic [DW-1:0] sel_d;

   always_comb begin
      sel_d = sel_q;
      if (wr_en_i) sel_d = wdata_i;
      if (susp_i)  sel_d = RST_VAL;   // clear beats write
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= RST_VAL;
      else        sel_q <= sel_d & WMASK;
   end

   assign rsel_o = sel_q;

endmodule

// File: rtl/gpio_rdom_lvl.sv
module gpio_rdom_lvl
   import gpio_rdom_pkg::*;
#(
   parameter int            DW        = 32,
   parameter logic [DW-1:0] IMPL_MASK = 32'h0000_0F0F,
   parameter logic [DW-1:0] LVL_INIT  = 32'h0000_00C0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  rst_evt_t      evt_i,
   input  logic          wr_en_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [DW-1:0] rsel_i,
   input  logic [DW-1:0] gpio_mode_i,
   input  logic [DW-1:0] dir_out_i,
   output logic [DW-1:0] lat_o,
   output logic [DW-1:0] pin_o,
   output logic [DW-1:0] pin_oe_o
);

   localparam logic [DW-1:0] RST_VAL = LVL_INIT & IMPL_MASK;

   logic [DW-1:0] lat_q;
   logic [DW-1:0] lat_d;
   logic [DW-1:0] clr;

   genvar i;
   generate
      for (i = 0; i < DW; i++) begin : g_bit
         // a suspend reset always clears; a broad event clears only broad-domain pins
         assign clr[i]   = evt_i.susp | (evt_i.broad & ~rsel_i[i]);
         assign lat_d[i] = clr[i]  ? LVL_INIT[i] :
                           wr_en_i ? wdata_i[i]  : lat_q[i];
         assign pin_oe_o[i] = IMPL_MASK[i] & gpio_mode_i[i] & dir_out_i[i];
         assign pin_o[i]    = lat_q[i] & pin_oe_o[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= RST_VAL;
      else        lat_q <= lat_d & IMPL_MASK;
   end

   assign lat_o = lat_q;

endmodule

// File: rtl/gpio_rdom_bank.sv
module gpio_rdom_bank
   import gpio_rdom_pkg::*;
#(
   parameter int             DW          = 32,
   parameter int             AW          = 4,
   parameter logic [AW-1:0]  LVL_ADDR    = 4'd0,
   parameter logic [AW-1:0]  RSEL_ADDR   = 4'd1,
   parameter logic [DW-1:0]  IMPL_MASK   = 32'h0000_0F0F,
   parameter logic [DW-1:0]  RSEL_WMASK  = 32'hFF00_FF00,
   parameter logic [DW-1:0]  LVL_INIT    = 32'h0000_00C0,
   parameter logic [DW-1:0]  RSEL_INIT   = 32'h0100_0000,
   parameter int             SYNC_STAGES = 2,
   parameter logic [7:0]     RCTL_CODE_A = 8'h06,
   parameter logic [7:0]     RCTL_CODE_B = 8'h0E
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel_i,
   input  logic          bus_wr_i,
   input  logic [AW-1:0] bus_addr_i,
   input  logic [DW-1:0] bus_wdata_i,
   output logic [DW-1:0] bus_rdata_o,
   input  logic          pwrok_fall_i,
   input  logic          rstctl_we_i,
   input  logic [7:0]    rstctl_data_i,
   input  logic          sys_rst_i,
   input  logic          susp_rst_i,
   input  logic [DW-1:0] gpio_mode_i,
   input  logic [DW-1:0] dir_out_i,
   input  logic [DW-1:0] pin_i,
   output logic [DW-1:0] pin_o,
   output logic [DW-1:0] pin_oe_o
);

   localparam int MAX_SYNC = 4;

   // elaboration-time parameter checks
   generate
      if (DW < 1) begin : g_bad_dw
         $error("gpio_rdom_bank: DW must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
         $error("gpio_rdom_bank: SYNC_STAGES out of range");
      end
      if (LVL_ADDR == RSEL_ADDR) begin : g_bad_addr
         $error("gpio_rdom_bank: register addresses collide");
      end
   endgenerate

   rst_evt_t      evt;
   logic          wr_lvl;
   logic          wr_rsel;
   logic [DW-1:0] lat_q;
   logic [DW-1:0] rsel_q;
   logic [DW-1:0] pin_sync;

   assign wr_lvl  = bus_sel_i & bus_wr_i & (bus_addr_i == LVL_ADDR);
   assign wr_rsel = bus_sel_i & bus_wr_i & (bus_addr_i == RSEL_ADDR);

   gpio_rdom_rstdec #(
      .RCTL_CODE_A (RCTL_CODE_A),
      .RCTL_CODE_B (RCTL_CODE_B)
   ) u_rstdec (
      .pwrok_fall_i  (pwrok_fall_i),
      .rstctl_we_i   (rstctl_we_i),
      .rstctl_data_i (rstctl_data_i),
      .sys_rst_i     (sys_rst_i),
      .susp_rst_i    (susp_rst_i),
      .evt_o         (evt)
   );

   gpio_rdom_rsel #(
      .DW    (DW),
      .WMASK (RSEL_WMASK),
      .INIT  (RSEL_INIT)
   ) u_rsel (
      .clk     (clk),
      .rst_n   (rst_n),
      .susp_i  (evt.susp),
      .wr_en_i (wr_rsel),
      .wdata_i (bus_wdata_i),
      .rsel_o  (rsel_q)
   );

   gpio_rdom_lvl #(
      .DW        (DW),
      .IMPL_MASK (IMPL_MASK),
      .LVL_INIT  (LVL_INIT)
   ) u_lvl (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .wr_en_i     (wr_lvl),
      .wdata_i     (bus_wdata_i),
      .rsel_i      (rsel_q),
      .gpio_mode_i (gpio_mode_i),
      .dir_out_i   (dir_out_i),
      .lat_o       (lat_q),
      .pin_o       (pin_o),
      .pin_oe_o    (pin_oe_o)
   );

   gpio_rdom_sync #(
      .DW     (DW),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_sync)
   );

   always_comb begin
      bus_rdata_o = '0;
      if (bus_sel_i) begin
         if (bus_addr_i == LVL_ADDR)       bus_rdata_o = pin_sync & IMPL_MASK;
         else if (bus_addr_i == RSEL_ADDR) bus_rdata_o = rsel_q;
      end
   end

endmodule

// File: rtl/gpio_rdom_chk.sv
module gpio_rdom_chk #(
   parameter int            DW          = 32,
   parameter int            AW          = 4,
   parameter logic [AW-1:0] LVL_ADDR    = 4'd0,
   parameter logic [AW-1:0] RSEL_ADDR   = 4'd1,
   parameter logic [DW-1:0] IMPL_MASK   = 32'h0000_0F0F,
   parameter logic [DW-1:0] RSEL_WMASK  = 32'hFF00_FF00,
   parameter logic [DW-1:0] LVL_INIT    = 32'h0000_00C0,
   parameter logic [DW-1:0] RSEL_INIT   = 32'h0100_0000,
   parameter logic [7:0]    RCTL_CODE_A = 8'h06,
   parameter logic [7:0]    RCTL_CODE_B = 8'h0E
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_sel_i,
   input logic          bus_wr_i,
   input logic [AW-1:0] bus_addr_i,
   input logic [DW-1:0] bus_wdata_i,
   input logic [DW-1:0] bus_rdata_o,
   input logic          pwrok_fall_i,
   input logic          rstctl_we_i,
   input logic [7:0]    rstctl_data_i,
   input logic          sys_rst_i,
   input logic          susp_rst_i,
   input logic [DW-1:0] gpio_mode_i,
   input logic [DW-1:0] dir_out_i,
   input logic [DW-1:0] pin_o,
   input logic [DW-1:0] pin_oe_o,
   input logic [DW-1:0] lat_q,
   input logic [DW-1:0] rsel_q
);

   logic broad_ev;
   logic lvl_wr;
   logic rsel_wr;

   assign broad_ev = pwrok_fall_i | sys_rst_i |
                     (rstctl_we_i & ((rstctl_data_i == RCTL_CODE_A) |
                                     (rstctl_data_i == RCTL_CODE_B)));
   assign lvl_wr   = bus_sel_i & bus_wr_i & (bus_addr_i == LVL_ADDR);
   assign rsel_wr  = bus_sel_i & bus_wr_i & (bus_addr_i == RSEL_ADDR);

   // R2
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe_o & ~(gpio_mode_i & dir_out_i & IMPL_MASK)) == '0);

   // R2
   drive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_o & ~pin_oe_o) == '0);

   // R5
   unimpl_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q & ~IMPL_MASK) == '0);

   // R5
   unimpl_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel_i && bus_addr_i == LVL_ADDR) |-> (bus_rdata_o & ~IMPL_MASK) == '0);

   // R6
   rsel_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsel_q & ~RSEL_WMASK) == '0);

   // R1
   lvl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_wr && !broad_ev && !susp_rst_i) |=> lat_q == ($past(bus_wdata_i) & IMPL_MASK));

   // R6
   rsel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsel_wr && !susp_rst_i) |=> rsel_q == ($past(bus_wdata_i) & RSEL_WMASK));

   // R7 R9: cleared bits reach the default even under a same-cycle write
   broad_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (broad_ev && !susp_rst_i) |=>
         ((lat_q ^ (LVL_INIT & IMPL_MASK)) & ~$past(rsel_q) & IMPL_MASK) == '0);

   // R7
   broad_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (broad_ev && !susp_rst_i && !lvl_wr) |=> ((lat_q ^ $past(lat_q)) & $past(rsel_q)) == '0);

   // R8
   susp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      susp_rst_i |=> (lat_q == (LVL_INIT & IMPL_MASK)) && (rsel_q == (RSEL_INIT & RSEL_WMASK)));

endmodule

bind gpio_rdom_bank gpio_rdom_chk #(
   .DW          (DW),
   .AW          (AW),
   .LVL_ADDR    (LVL_ADDR),
   .RSEL_ADDR   (RSEL_ADDR),
   .IMPL_MASK   (IMPL_MASK),
   .RSEL_WMASK  (RSEL_WMASK),
   .LVL_INIT    (LVL_INIT),
   .RSEL_INIT   (RSEL_INIT),
   .RCTL_CODE_A (RCTL_CODE_A),
   .RCTL_CODE_B (RCTL_CODE_B)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_sel_i     (bus_sel_i),
   .bus_wr_i      (bus_wr_i),
   .bus_addr_i    (bus_addr_i),
   .bus_wdata_i   (bus_wdata_i),
   .bus_rdata_o   (bus_rdata_o),
   .pwrok_fall_i  (pwrok_fall_i),
   .rstctl_we_i   (rstctl_we_i),
   .rstctl_data_i (rstctl_data_i),
   .sys_rst_i     (sys_rst_i),
   .susp_rst_i    (susp_rst_i),
   .gpio_mode_i   (gpio_mode_i),
   .dir_out_i     (dir_out_i),
   .pin_o         (pin_o),
   .pin_oe_o      (pin_oe_o),
   .lat_q         (lat_q),
   .rsel_q        (rsel_q)
);

// File: tb/gpio_rdom_bank_bench.sv
module gpio_rdom_bank_bench;

   localparam int          CLK_PERIOD = 10;
   localparam int          DW    = 32;
   localparam int          AW    = 4;
   localparam logic [31:0] IMPL  = 32'h0000_0F0F;
   localparam logic [31:0] WMSK  = 32'hFF00_FF00;
   localparam logic [31:0] LINIT = 32'h0000_0A05;
   localparam logic [31:0] RINIT = 32'h0000_0300;
   localparam int          SYNC  = 2;
   localparam logic [3:0]  A_LVL = 4'd0;
   localparam logic [3:0]  A_RSL = 4'd1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          pwrok = 1'b0, rctl_we = 1'b0, sys_rst = 1'b0, susp = 1'b0;
   logic [7:0]    rctl_data = '0;
   logic [DW-1:0] gmode = '1, dout = '1, pin_in = '0;
   logic [DW-1:0] pin_out, pin_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_rdom_bank #(
      .DW(DW), .AW(AW), .LVL_ADDR(A_LVL), .RSEL_ADDR(A_RSL),
      .IMPL_MASK(IMPL), .RSEL_WMASK(WMSK), .LVL_INIT(LINIT), .RSEL_INIT(RINIT),
      .SYNC_STAGES(SYNC), .RCTL_CODE_A(8'h06), .RCTL_CODE_B(8'h0E)
   ) u_gpio_rdom_bank (
      .clk(clk), .rst_n(rst_n), .bus_sel_i(bus_sel), .bus_wr_i(bus_wr),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .pwrok_fall_i(pwrok), .rstctl_we_i(rctl_we), .rstctl_data_i(rctl_data),
      .sys_rst_i(sys_rst), .susp_rst_i(susp), .gpio_mode_i(gmode),
      .dir_out_i(dout), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_lat, m_rsel;
   logic [31:0] m_pq[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_lat  <= LINIT & IMPL;
         m_rsel <= RINIT & WMSK;
         m_pq.delete();
         for (int k = 0; k < SYNC; k++) m_pq.push_back('0);
      end else begin
         logic [31:0] nl, nr;
         logic broad;
         broad = pwrok || sys_rst ||
                 (rctl_we && (rctl_data == 8'h06 || rctl_data == 8'h0E));
         nl = m_lat;
         nr = m_rsel;
         if (bus_sel && bus_wr && bus_addr == A_LVL) nl = bus_wdata & IMPL;
         if (bus_sel && bus_wr && bus_addr == A_RSL) nr = bus_wdata & WMSK;
         for (int b = 0; b < 32; b++)
            if (susp || (broad && !m_rsel[b])) nl[b] = LINIT[b] & IMPL[b];
         if (susp) nr = RINIT & WMSK;
         m_lat  <= nl;
         m_rsel <= nr;
         m_pq.push_back(pin_in);
         void'(m_pq.pop_front());
      end
   end

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
      end
   endtask

   // compare every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [31:0] eoe, eo, erd;
         eoe = IMPL & gmode & dout;
         eo  = m_lat & eoe;
         erd = '0;
         if (bus_sel && bus_addr == A_LVL) erd = m_pq[0] & IMPL;
         else if (bus_sel && bus_addr == A_RSL) erd = m_rsel;
         check(pin_oe === eoe, "R2 oe", pin_oe, eoe);
         check(pin_out === eo, "R2 pin", pin_out, eo);
         check(bus_rdata === erd, "R4 rdata", bus_rdata, erd);
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); #1;
      bus_wr = 0; bus_sel = 0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse(input int k, input logic [7:0] code);
      @(negedge clk); #1;
      case (k)
         0: pwrok = 1;
         1: sys_rst = 1;
         2: begin rctl_we = 1; rctl_data = code; end
         default: susp = 1;
      endcase
      @(negedge clk); #1;
      pwrok = 0; sys_rst = 0; rctl_we = 0; susp = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      @(negedge clk); #1;

      // R10 reset state
      check(pin_out === 32'h0A05, "R10 latch default", pin_out, 32'h0A05);
      rd(A_RSL, r);
      check(r === 32'h0300, "R10 select default", r, 32'h0300);
      rd(A_LVL, r);
      check(r === 32'h0, "R4 idle pins", r, 32'h0);

      // R1 write drives pins
      wr(A_LVL, 32'h0000_0C03);
      check(pin_out === 32'h0C03, "R1 drive", pin_out, 32'h0C03);

      // R5 unimplemented bits
      wr(A_LVL, 32'hFFFF_FFFF);
      check(pin_out === 32'h0F0F, "R5 pin mask", pin_out, 32'h0F0F);
      check(pin_oe === 32'h0F0F, "R5 oe mask", pin_oe, 32'h0F0F);

      // R3 native mode
      gmode = ~32'h1;
      wr(A_LVL, 32'h0000_0F0E);
      check(pin_oe === 32'h0F0E, "R3 native oe", pin_oe, 32'h0F0E);
      wr(A_LVL, 32'h0000_0F0E);
      check(pin_out === 32'h0F0E, "R3 native no drive", pin_out, 32'h0F0E);
      gmode = '1;
      #1 check(pin_out === 32'h0F0E, "R3 stored value", pin_out, 32'h0F0E);

      // R2 direction gating
      dout = 32'hFFFF_F0FF;
      #1 check(pin_oe === 32'h000F, "R2 dir gate", pin_oe, 32'h000F);
      check(pin_out === 32'h000E, "R2 dir drive", pin_out, 32'h000E);
      dout = '1;

      // R4 read path latency and source
      wr(A_LVL, 32'h0000_0F0F);
      bus_sel = 1; bus_addr = A_LVL; pin_in = 32'h1234_5A5A;
      @(negedge clk); #1;
      check(bus_rdata === 32'h0, "R4 one edge", bus_rdata, 32'h0);
      @(negedge clk); #1;
      check(bus_rdata === 32'h0A0A, "R4 two edges", bus_rdata, 32'h0A0A);

      // R6 select writable bits
      wr(A_RSL, 32'hFFFF_FFFF);
      rd(A_RSL, r);
      check(r === 32'hFF00_FF00, "R6 rsel mask", r, 32'hFF00_FF00);
      wr(A_RSL, 32'h0000_0500);
      rd(A_RSL, r);
      check(r === 32'h0500, "R6 rsel value", r, 32'h0500);

      // R7 broad events
      wr(A_LVL, 32'h0F0F);
      pulse(0, 8'h00);
      check(pin_out === 32'h0F05, "R7 power-good", pin_out, 32'h0F05);
      wr(A_LVL, 32'h0F0F);
      pulse(2, 8'h04);
      check(pin_out === 32'h0F0F, "R7 other code ignored", pin_out, 32'h0F0F);
      pulse(2, 8'h0E);
      check(pin_out === 32'h0F05, "R7 code B", pin_out, 32'h0F05);
      wr(A_LVL, 32'h0F0F);
      pulse(2, 8'h06);
      check(pin_out === 32'h0F05, "R7 code A", pin_out, 32'h0F05);
      wr(A_LVL, 32'h0F0F);
      pulse(1, 8'h00);
      check(pin_out === 32'h0F05, "R7 system reset", pin_out, 32'h0F05);

      // R9 clear beats write
      @(negedge clk); #1;
      bus_sel = 1; bus_wr = 1; bus_addr = A_LVL; bus_wdata = 32'h0F0F; pwrok = 1;
      @(negedge clk); #1;
      bus_wr = 0; bus_sel = 0; pwrok = 0;
      check(pin_out === 32'h0F05, "R9 level collision", pin_out, 32'h0F05);
      @(negedge clk); #1;
      bus_sel = 1; bus_wr = 1; bus_addr = A_RSL; bus_wdata = 32'hFF00; susp = 1;
      @(negedge clk); #1;
      bus_wr = 0; susp = 0;
      rd(A_RSL, r);
      check(r === 32'h0300, "R9 select collision", r, 32'h0300);

      // R8 suspend reset
      wr(A_RSL, 32'hFF00_FF00);
      wr(A_LVL, 32'h0F0F);
      pulse(3, 8'h00);
      check(pin_out === 32'h0A05, "R8 latch", pin_out, 32'h0A05);
      rd(A_RSL, r);
      check(r === 32'h0300, "R8 select", r, 32'h0300);

      // mixed random traffic, compared against the model each clock
      for (int i = 0; i < 600; i++) begin
         @(negedge clk); #1;
         bus_sel   = $urandom_range(0, 1);
         bus_wr    = $urandom_range(0, 1);
         bus_addr  = 4'($urandom_range(0, 2));
         bus_wdata = $urandom;
         pwrok     = ($urandom_range(0, 15) == 0);
         sys_rst   = ($urandom_range(0, 19) == 0);
         susp      = ($urandom_range(0, 39) == 0);
         rctl_we   = ($urandom_range(0, 9) == 0);
         case ($urandom_range(0, 3))
            0: rctl_data = 8'h06;
            1: rctl_data = 8'h0E;
            2: rctl_data = 8'h04;
            default: rctl_data = 8'($urandom);
         endcase
         gmode  = $urandom;
         dout   = $urandom;
         pin_in = $urandom;
      end
      @(negedge clk); #1;
      bus_sel = 0; bus_wr = 0; pwrok = 0; sys_rst = 0; susp = 0; rctl_we = 0;
      repeat (3) @(negedge clk);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule